// File: doc/BRIEF.md
# Runahead Prefetch Filter Queue

While a core runs ahead under a long cache miss, every load with a known address that would also miss becomes a prefetch candidate. This block takes those candidates one per cycle, sorts out the ones that cannot be fetched or are already on their way, and keeps the rest in a small first-in first-out queue. The queue feeds the memory system over a valid/ready request channel.

Issued requests move into an in-flight table, so several line fetches can be outstanding at the same time. An entry leaves the table when a response naming its line comes back. Any new candidate whose 32-byte line is already queued or in flight is dropped as a duplicate. Each candidate's fate is recorded in one of four saturating counters:

- accepted
- dropped because the queue was full
- dropped for an unknown address
- dropped as a duplicate

Queued requests stay in place when runahead ends, because they still warm the cache.

Top module: `ra_prefetch_queue`

## Requirements
- R1: After a synchronous reset, `req_valid` is low and all four outcome counters read zero.
- R2: A cycle counts as a candidate only when `cand_valid` and `cand_miss` are both high. Otherwise the input changes no counter and queues nothing.
- R3: A candidate with `cand_addr_ok` low is dropped and the bad-address counter rises by one. This class has the highest priority.
- R4: A candidate with a known address is dropped as a duplicate, and the duplicate counter rises by one, when its line (`cand_addr[31:5]`) equals a queued line or an in-flight line. This test comes before the full test.
- R5: The queue holds 8 lines. A non-duplicate candidate with a known address that arrives while 8 lines are held is dropped and counts as full, even if a request leaves in the same cycle.
- R6: Any other candidate is accepted and the accepted counter rises by one. Its line appears on `req_line` no earlier than the next cycle, and lines are issued in arrival order.
- R7: A request transfers when `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid` stays high and `req_line` keeps its value.
- R8: At most 8 lines are in flight. `req_valid` is high exactly when the queue is non-empty and the table has a free slot. A `resp_valid` pulse frees the entry whose line equals `resp_line`. A response that names no in-flight line has no effect.
- R9: Each counter is 16 bits wide and holds at 65535 instead of wrapping.
- R10: `stat_clear` sets all four counters to zero on the next cycle, wins over an increment in the same cycle, and leaves the queue and the in-flight table untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | A load is presented this cycle |
| cand_addr | input | 32 | Byte address of the load |
| cand_addr_ok | input | 1 | The address register holds a known value |
| cand_miss | input | 1 | The load would miss in the cache |
| req_valid | output | 1 | A prefetch request is offered |
| req_line | output | 27 | Line address of the offered request |
| req_ready | input | 1 | Memory side takes the request |
| resp_valid | input | 1 | A line fetch has completed |
| resp_line | input | 27 | Line address of the completed fetch |
| stat_clear | input | 1 | Zero all outcome counters |
| cnt_accepted | output | 16 | Accepted candidates |
| cnt_full | output | 16 | Candidates dropped on a full queue |
| cnt_badaddr | output | 16 | Candidates dropped for an unknown address |
| cnt_dup | output | 16 | Candidates dropped as duplicates |

## Verification
A lost or stale queue slot shows up within one cycle in one of three ways: the wrong line on `req_line`, a `req_valid` that should not be there, or a missing `req_valid`. A wrong in-flight entry shows up in two ways. First, `req_valid` stays low even though slots are free, or goes high while 8 lines are still outstanding. Second, a repeat candidate lands in the wrong counter on the very next cycle. The reference model therefore compares the request channel and all four counters after every clock. Directed phases fill the queue and the table, send stray responses, saturate a counter and clear the counters while the queue is busy.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LINE_BYTES = 32;
    localparam int DEF_QDEPTH     = 8;
    localparam int DEF_SLOTS      = 8;
    localparam int DEF_CNT_W      = 16;
    localparam int NUM_OUTCOMES   = 4;

    // Fate of one presented load; NONE means it was not a candidate.
    typedef enum logic [2:0] {
        OUT_NONE,
        OUT_ACCEPT,
        OUT_FULL,
        OUT_BADADDR,
        OUT_DUP
    } outcome_e;

    // Counter select: bit 0 accepted, 1 full, 2 bad address, 3 duplicate.
    function automatic logic [NUM_OUTCOMES-1:0] outcome_bits(input outcome_e o);
        case (o)
            OUT_ACCEPT:  return 4'b0001;
            OUT_FULL:    return 4'b0010;
            OUT_BADADDR: return 4'b0100;
            OUT_DUP:     return 4'b1000;
            default:     return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
    parameter int W     = 27,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    input  logic [W-1:0] probe,
    output logic         probe_hit
);

    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] hit;
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            occ  <= '0;
        end else begin
            if (pop) begin
                rptr      <= adv(rptr);
                occ[rptr] <= 1'b0;
            end
            if (push) begin
                wptr      <= adv(wptr);
                occ[wptr] <= 1'b1;
            end
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = occ[g] && (mem[g] == probe);
    end
    assign probe_hit = |hit;

endmodule

// File: rtl/pfq_inflight.sv
module pfq_inflight #(
    parameter int W     = 27,
    parameter int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         alloc,
    input  logic [W-1:0] alloc_line,
    input  logic         rel,
    input  logic [W-1:0] rel_line,
    input  logic [W-1:0] probe,
    output logic         probe_hit,
    output logic         has_free
);

    logic [W-1:0]     slot_line [SLOTS];
    logic [SLOTS-1:0] busy;
    logic [SLOTS-1:0] hit;
    logic [IDX_W-1:0] free_idx;

    // Lowest free slot.
    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!busy[i] && !has_free) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (rel && busy[i] && (slot_line[i] == rel_line)) busy[i] <= 1'b0;
            end
            if (alloc && has_free) busy[free_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (alloc && has_free) slot_line[free_idx] <= alloc_line;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign hit[g] = busy[g] && (slot_line[g] == probe);
    end
    assign probe_hit = |hit;

endmodule

// File: rtl/pfq_stats.sv
module pfq_stats #(
    parameter int CNT_W = 16,
    parameter int N     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic [N-1:0]            inc,
    output logic [N-1:0][CNT_W-1:0] value
);

    logic [CNT_W-1:0] ctr [N];

    for (genvar g = 0; g < N; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                ctr[g] <= '0;
            end else if (inc[g] && (ctr[g] != '1)) begin
                ctr[g] <= ctr[g] + 1'b1;
            end
        end
        assign value[g] = ctr[g];
    end

endmodule

// File: rtl/ra_prefetch_queue.sv
module ra_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int QDEPTH     = DEF_QDEPTH,
    parameter int SLOTS      = DEF_SLOTS,
    parameter int CNT_W      = DEF_CNT_W,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic              cand_addr_ok,
    input  logic              cand_miss,
    output logic              req_valid,
    output logic [LINE_W-1:0] req_line,
    input  logic              req_ready,
    input  logic              resp_valid,
    input  logic [LINE_W-1:0] resp_line,
    input  logic              stat_clear,
    output logic [CNT_W-1:0]  cnt_accepted,
    output logic [CNT_W-1:0]  cnt_full,
    output logic [CNT_W-1:0]  cnt_badaddr,
    output logic [CNT_W-1:0]  cnt_dup
);

    logic [LINE_W-1:0] cand_line;
    logic              offset_unused;
    logic              q_hit, q_empty, q_full;
    logic              f_hit, f_free;
    logic              push, pop;
    outcome_e          outcome;
    logic [NUM_OUTCOMES-1:0]            inc;
    logic [NUM_OUTCOMES-1:0][CNT_W-1:0] stats;

    assign cand_line     = cand_addr[ADDR_W-1:OFF_W];
    assign offset_unused = ^cand_addr[OFF_W-1:0];

    // Priority: unknown address, duplicate, full, accept.
    always_comb begin
        outcome = OUT_NONE;
        if (cand_valid && cand_miss) begin
            if (!cand_addr_ok)         outcome = OUT_BADADDR;
            else if (q_hit || f_hit)   outcome = OUT_DUP;
            else if (q_full)           outcome = OUT_FULL;
            else                       outcome = OUT_ACCEPT;
        end
    end

    assign inc       = outcome_bits(outcome);
    assign push      = (outcome == OUT_ACCEPT);
    assign req_valid = !q_empty && f_free;
    assign pop       = req_valid && req_ready;

    pfq_fifo #(.W(LINE_W), .DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (cand_line),
        .pop       (pop),
        .head      (req_line),
        .empty     (q_empty),
        .full      (q_full),
        .probe     (cand_line),
        .probe_hit (q_hit)
    );

    pfq_inflight #(.W(LINE_W), .SLOTS(SLOTS)) u_inflight (
        .clk        (clk),
        .rst        (rst),
        .alloc      (pop),
        .alloc_line (req_line),
        .rel        (resp_valid),
        .rel_line   (resp_line),
        .probe      (cand_line),
        .probe_hit  (f_hit),
        .has_free   (f_free)
    );

    pfq_stats #(.CNT_W(CNT_W), .N(NUM_OUTCOMES)) u_stats (
        .clk   (clk),
        .rst   (rst),
        .clear (stat_clear),
        .inc   (inc),
        .value (stats)
    );

    assign cnt_accepted = stats[0];
    assign cnt_full     = stats[1];
    assign cnt_badaddr  = stats[2];
    assign cnt_dup      = stats[3];

endmodule

// File: rtl/ra_prefetch_queue_chk.sv
module ra_prefetch_queue_chk #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 27,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cand_valid,
    input logic [ADDR_W-1:0] cand_addr,
    input logic              cand_addr_ok,
    input logic              cand_miss,
    input logic              req_valid,
    input logic [LINE_W-1:0] req_line,
    input logic              req_ready,
    input logic              stat_clear,
    input logic [CNT_W-1:0]  cnt_accepted,
    input logic [CNT_W-1:0]  cnt_full,
    input logic [CNT_W-1:0]  cnt_badaddr,
    input logic [CNT_W-1:0]  cnt_dup
);

    logic addr_seen;
    assign addr_seen = ^cand_addr;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_line));

    // R10
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stat_clear |=> (cnt_accepted == '0) && (cnt_full == '0)
                       && (cnt_badaddr == '0) && (cnt_dup == '0));

    // R3
    badaddr_count_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid && cand_miss && !cand_addr_ok && !stat_clear && (cnt_badaddr != '1)
        |=> cnt_badaddr == $past(cnt_badaddr) + 1'b1);

    // R2
    nonmiss_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !(cand_valid && cand_miss) && !stat_clear
        |=> $stable(cnt_accepted) && $stable(cnt_full)
            && $stable(cnt_badaddr) && $stable(cnt_dup));

    // R6
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_clear |=> $countones({cnt_accepted != $past(cnt_accepted),
                                    cnt_full     != $past(cnt_full),
                                    cnt_badaddr  != $past(cnt_badaddr),
                                    cnt_dup      != $past(cnt_dup)}) <= 1);

    // R9
    sat_badaddr_chk: assert property (@(posedge clk) disable iff (rst)
        (&cnt_badaddr) && !stat_clear |=> &cnt_badaddr);

    // R9
    sat_accepted_chk: assert property (@(posedge clk) disable iff (rst)
        (&cnt_accepted) && !stat_clear |=> &cnt_accepted);

    always_comb begin
        if (!rst && cand_valid && cand_addr_ok) begin
            // R3
            addr_known_chk: assert (!$isunknown(addr_seen));
        end
    end

endmodule

bind ra_prefetch_queue ra_prefetch_queue_chk #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cand_valid   (cand_valid),
    .cand_addr    (cand_addr),
    .cand_addr_ok (cand_addr_ok),
    .cand_miss    (cand_miss),
    .req_valid    (req_valid),
    .req_line     (req_line),
    .req_ready    (req_ready),
    .stat_clear   (stat_clear),
    .cnt_accepted (cnt_accepted),
    .cnt_full     (cnt_full),
    .cnt_badaddr  (cnt_badaddr),
    .cnt_dup      (cnt_dup)
);

// File: tb/ra_prefetch_queue_tb.sv
`timescale 1ns/1ps
module ra_prefetch_queue_tb;

    localparam int LW   = 27;
    localparam int QD   = 8;
    localparam int FD   = 8;
    localparam int CMAX = 65535;

    logic          clk = 1'b0;
    logic          rst;
    logic          cand_valid, cand_addr_ok, cand_miss;
    logic [31:0]   cand_addr;
    logic          req_valid, req_ready;
    logic [LW-1:0] req_line;
    logic          resp_valid;
    logic [LW-1:0] resp_line;
    logic          stat_clear;
    logic [15:0]   cnt_accepted, cnt_full, cnt_badaddr, cnt_dup;

    always #2.5 clk = ~clk;

    ra_prefetch_queue u_dut (
        .clk(clk), .rst(rst),
        .cand_valid(cand_valid), .cand_addr(cand_addr),
        .cand_addr_ok(cand_addr_ok), .cand_miss(cand_miss),
        .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_line(resp_line),
        .stat_clear(stat_clear),
        .cnt_accepted(cnt_accepted), .cnt_full(cnt_full),
        .cnt_badaddr(cnt_badaddr), .cnt_dup(cnt_dup)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    // Reference model state
    logic [LW-1:0] mq[$];
    logic [LW-1:0] mf[$];
    int m_acc = 0, m_full = 0, m_bad = 0, m_dup = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_rv();
        return (mq.size() > 0) && (mf.size() < FD);
    endfunction

    task automatic compare();
        chk(req_valid == exp_rv(), "R8", "req_valid", req_valid, exp_rv());
        if (exp_rv()) chk(req_line == mq[0], "R6", "req_line order", req_line, mq[0]);
        chk(cnt_accepted == m_acc,  "R6", "cnt_accepted", cnt_accepted, m_acc);
        chk(cnt_full     == m_full, "R5", "cnt_full",     cnt_full,     m_full);
        chk(cnt_badaddr  == m_bad,  "R3", "cnt_badaddr",  cnt_badaddr,  m_bad);
        chk(cnt_dup      == m_dup,  "R4", "cnt_dup",      cnt_dup,      m_dup);
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic step(input bit cv, input logic [LW-1:0] ln, input logic [4:0] off,
                        input bit ok, input bit miss, input bit rdy,
                        input bit rv, input logic [LW-1:0] rl, input bit clr);
        bit pop, hit;
        int cls;
        cand_valid   = cv;
        cand_addr    = {ln, off};
        cand_addr_ok = ok;
        cand_miss    = miss;
        req_ready    = rdy;
        resp_valid   = rv;
        resp_line    = rl;
        stat_clear   = clr;

        pop = exp_rv() && rdy;
        hit = 0;
        foreach (mq[i]) if (mq[i] == ln) hit = 1;
        foreach (mf[i]) if (mf[i] == ln) hit = 1;
        cls = 0;
        if (cv && miss) begin
            if (!ok)                  cls = 3;
            else if (hit)             cls = 4;
            else if (mq.size() == QD) cls = 2;
            else                      cls = 1;
        end
        if (rv) begin
            for (int i = 0; i < mf.size(); i++) begin
                if (mf[i] == rl) begin
                    mf.delete(i);
                    break;
                end
            end
        end
        if (pop) mf.push_back(mq.pop_front());
        if (cls == 1) mq.push_back(ln);
        if (clr) begin
            m_acc = 0; m_full = 0; m_bad = 0; m_dup = 0;
        end else begin
            if (cls == 1 && m_acc  < CMAX) m_acc++;
            if (cls == 2 && m_full < CMAX) m_full++;
            if (cls == 3 && m_bad  < CMAX) m_bad++;
            if (cls == 4 && m_dup  < CMAX) m_dup++;
        end

        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input bit rdy);
        step(0, '0, '0, 0, 0, rdy, 0, '0, 0);
    endtask

    task automatic drain();
        for (int n = 0; n < 100; n++) begin
            if (mq.size() == 0 && mf.size() == 0) break;
            step(0, '0, '0, 0, 0, 1, mf.size() > 0, (mf.size() > 0) ? mf[0] : '0, 0);
        end
        chk(mq.size() == 0 && mf.size() == 0 && !req_valid, "R8", "drain complete",
            req_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; cand_valid = 0; cand_addr = '0; cand_addr_ok = 0; cand_miss = 0;
        req_ready = 0; resp_valid = 0; resp_line = '0; stat_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        chk(req_valid == 0, "R1", "req_valid after reset", req_valid, 0);
        chk(cnt_accepted == 0 && cnt_full == 0 && cnt_badaddr == 0 && cnt_dup == 0,
            "R1", "counters after reset",
            cnt_accepted + cnt_full + cnt_badaddr + cnt_dup, 0);

        // R2 loads that would hit are not candidates
        for (int i = 0; i < 4; i++) step(1, LW'(5 + i), 5'(i), 1, 0, 0, 0, '0, 0);
        chk(!req_valid && cnt_accepted == 0 && cnt_dup == 0 && cnt_full == 0,
            "R2", "non-miss ignored", cnt_accepted, 0);

        // R6 / R5 fill the queue with the memory side stalled
        for (int i = 0; i < 10; i++) step(1, LW'(100 + i), 5'(i), 1, 1, 0, 0, '0, 0);
        chk(cnt_accepted == 8, "R6", "accepted after fill", cnt_accepted, 8);
        chk(cnt_full == 2, "R5", "full drops", cnt_full, 2);

        // R4 same line, different byte offset
        step(1, LW'(103), 5'd31, 1, 1, 0, 0, '0, 0);
        chk(cnt_dup == 1, "R4", "duplicate of queued line", cnt_dup, 1);
        // R3 unknown address wins over a duplicate line
        step(1, LW'(103), 5'd0, 0, 1, 0, 0, '0, 0);
        chk(cnt_badaddr == 1 && cnt_dup == 1, "R3", "bad address priority", cnt_badaddr, 1);

        // R7 request holds while ready is low
        for (int i = 0; i < 8; i++) begin
            step(0, '0, '0, 0, 0, i[0], 0, '0, 0);
            if (!i[0]) chk(req_valid == 1, "R7", "valid held", req_valid, 1);
        end
        for (int i = 0; i < 6; i++) idle(1);

        // R8 table holds 8 lines; queue now blocked
        for (int i = 0; i < 3; i++) step(1, LW'(200 + i), 5'd0, 1, 1, 1, 0, '0, 0);
        chk(req_valid == 0, "R8", "no issue with table full", req_valid, 0);
        step(1, LW'(100), 5'd3, 1, 1, 1, 0, '0, 0);
        chk(cnt_dup == 2, "R4", "duplicate of in-flight line", cnt_dup, 2);
        step(0, '0, '0, 0, 0, 1, 1, LW'(999), 0);
        chk(req_valid == 0, "R8", "stray response ignored", req_valid, 0);
        step(0, '0, '0, 0, 0, 0, 1, LW'(100), 0);
        chk(req_valid == 1 && req_line == LW'(200), "R8", "slot freed by response",
            req_line, 200);
        drain();

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bit cv, ok, miss, rdy, rv, clr;
            logic [LW-1:0] ln, rl;
            cv   = ($urandom_range(1) == 1);
            miss = ($urandom_range(9) < 8);
            ok   = ($urandom_range(9) < 9);
            ln   = LW'($urandom_range(15));
            rdy  = ($urandom_range(9) < 6);
            rv   = ($urandom_range(9) < 3);
            rl   = (mf.size() > 0) ? mf[$urandom_range(mf.size() - 1)] : LW'($urandom_range(15));
            clr  = ($urandom_range(99) == 0);
            step(cv, ln, 5'($urandom_range(31)), ok, miss, rdy, rv, rl, clr);
        end
        drain();

        // R10 clear wins over a same-cycle accept, queue untouched
        step(1, LW'(300), 5'd0, 1, 1, 0, 0, '0, 1);
        chk(cnt_accepted == 0, "R10", "clear beats increment", cnt_accepted, 0);
        chk(req_valid == 1 && req_line == LW'(300), "R10", "queue kept over clear",
            req_line, 300);
        drain();

        // R9 saturation
        for (int n = 0; n < CMAX + 5; n++) step(1, LW'(7), 5'd0, 0, 1, 0, 0, '0, 0);
        chk(cnt_badaddr == 16'hFFFF, "R9", "bad address counter saturates", cnt_badaddr, CMAX);
        step(0, '0, '0, 0, 0, 0, 0, '0, 1);
        chk(cnt_badaddr == 0, "R10", "clear after saturation", cnt_badaddr, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule